// File: doc/BRIEF.md
# Gap-Length Tag Write Modulator

This block drives the reader-field control line used to program a low-frequency transponder. When a start pulse is taken, it first leaves the field on for a charge interval that powers the tag. It then transmits a fixed 14-byte write frame, one bit every bit slot, and finally holds the field on for a programming interval. At the end it raises a one-cycle completion pulse. Each bit is sent as a field-off gap at the start of a constant-length slot. The slot is filled with carrier for its remainder, and the gap length alone tells a one from a zero.

The caller supplies a 64-bit payload and a 16-bit checksum, and both are captured when the start pulse is taken. All intervals are given in microseconds. A free prescaler, cleared while the block is idle, turns the system clock into a microsecond tick. Each interval therefore lasts exactly its microsecond count multiplied by the clocks-per-microsecond parameter.

Top module: `tw_write_modulator`

## Requirements
- R1: After reset, and whenever the block is idle, `field_mod` is 0 (field on), `busy` is 0 and `done` is 0.
- R2: A start pulse taken while idle makes `busy` high from the next cycle. `field_mod` then stays 0 for CHARGE_US*CLKS_PER_US cycles.
- R3: A one bit is `field_mod`=1 for ONE_OFF_US*CLKS_PER_US cycles, followed by `field_mod`=0 for (BIT_US-ONE_OFF_US)*CLKS_PER_US cycles.
- R4: A zero bit is `field_mod`=1 for ZERO_OFF_US*CLKS_PER_US cycles, followed by `field_mod`=0 for (BIT_US-ZERO_OFF_US)*CLKS_PER_US cycles.
- R5: The frame is 14 bytes sent in this order: 8'hBB, 8'hEB, payload bytes 0 to 7 (bits [7:0] first, bits [63:56] last), checksum bits [7:0], checksum bits [15:8], 8'h00, 8'h03.
- R6: Within every byte, bit 0 is sent first and bit 7 last.
- R7: After the last bit slot, `field_mod` stays 0 with `busy` high for PROG_US*CLKS_PER_US cycles. In the next cycle `done` is 1 and `busy` is 0, and `done` lasts exactly one cycle.
- R8: A start pulse while `busy` is high has no effect on the waveform or on its length.
- R9: Changes on `tag_data` or `tag_crc` while `busy` is high do not alter the frame; the values captured at start are sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a write sequence (taken only when idle) |
| tag_data | input | 64 | Payload to write |
| tag_crc | input | 16 | Checksum sent after the payload |
| field_mod | output | 1 | 1 = field off (modulating), 0 = field on |
| busy | output | 1 | High from the cycle after start until the sequence ends |
| done | output | 1 | One-cycle pulse when the programming interval ends |

## Verification
The hardest case to reach is a second start pulse, together with new payload values, arriving while a frame is partly sent. Ports alone cannot show that the sequencer was not restarted or re-read. For some runs the bench picks a random cycle inside the frame and pulses start while changing the payload and checksum there. It then demands that every remaining slot still carries the originally captured bits and that completion lands on the unchanged cycle. Payloads with all zeros, all ones and random values make sure both gap lengths appear in every byte position.

// File: rtl/tw_pkg.sv
package tw_pkg;

  typedef enum logic [2:0] {
    TW_IDLE,
    TW_CHARGE,
    TW_GAP,
    TW_CARRIER,
    TW_PROGRAM
  } tw_state_t;

  localparam int unsigned FRAME_BYTES = 14;
  localparam int unsigned FRAME_BITS  = FRAME_BYTES * 8;
  localparam int unsigned POS_W       = $clog2(FRAME_BITS);

  // Byte at position idx of the write frame (R5)
  function automatic logic [7:0] frame_byte(input logic [3:0] idx,
                                            input logic [63:0] d,
                                            input logic [15:0] c);
    logic [7:0] b;
    case (idx)
      4'd0:    b = 8'hBB;
      4'd1:    b = 8'hEB;
      4'd10:   b = c[7:0];
      4'd11:   b = c[15:8];
      4'd12:   b = 8'h00;
      4'd13:   b = 8'h03;
      default: b = (idx >= 4'd2 && idx <= 4'd9) ? d[8*(idx-4'd2) +: 8] : 8'h00;
    endcase
    return b;
  endfunction

  // Bit at serial position pos, least significant bit of each byte first (R6)
  function automatic logic frame_bit(input logic [POS_W-1:0] pos,
                                     input logic [63:0] d,
                                     input logic [15:0] c);
    logic [7:0] b;
    b = frame_byte(pos[POS_W-1:3], d, c);
    return b[pos[2:0]];
  endfunction

endpackage

// File: rtl/tw_us_tick.sv
module tw_us_tick #(
  parameter int unsigned CLKS_PER_US = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned PW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;

  generate
    if (CLKS_PER_US <= 1) begin : g_direct
      assign tick = run;
    end else begin : g_prescale
      logic [PW-1:0] pre;
      logic          wrap;
      assign wrap = (pre == PW'(CLKS_PER_US - 1));
      assign tick = run && wrap;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     pre <= '0;
        else if (!run)  pre <= '0;
        else if (wrap)  pre <= '0;
        else            pre <= pre + PW'(1);
      end

      // Ticks are CLKS_PER_US cycles apart, never back to back (R2)
      assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/tw_seg_timer.sv
module tw_seg_timer #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic [CW-1:0] seg_len,
  output logic          seg_end
);
  logic [CW-1:0] us_cnt;

  assign seg_end = run && tick && (us_cnt == seg_len - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                us_cnt <= '0;
    else if (!run || seg_end)  us_cnt <= '0;
    else if (tick)             us_cnt <= us_cnt + CW'(1);
  end

  // The count never passes the length of the running interval (R2, R3, R4)
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (us_cnt < seg_len));

endmodule

// File: rtl/tw_frame_source.sv
module tw_frame_source
  import tw_pkg::*;
(
  input  logic [POS_W-1:0] pos,
  input  logic [63:0]      data_q,
  input  logic [15:0]      crc_q,
  output logic             bit_val
);
  assign bit_val = frame_bit(pos, data_q, crc_q);
endmodule

// File: rtl/tw_write_modulator.sv
module tw_write_modulator
  import tw_pkg::*;
#(
  parameter int unsigned CLKS_PER_US = 24,
  parameter int unsigned CHARGE_US   = 50000,
  parameter int unsigned BIT_US      = 2000,
  parameter int unsigned ONE_OFF_US  = 1000,
  parameter int unsigned ZERO_OFF_US = 300,
  parameter int unsigned PROG_US     = 50000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [63:0] tag_data,
  input  logic [15:0] tag_crc,
  output logic        field_mod,
  output logic        busy,
  output logic        done
);
  localparam int unsigned MAX_A  = (CHARGE_US > PROG_US) ? CHARGE_US : PROG_US;
  localparam int unsigned MAX_US = (MAX_A > BIT_US) ? MAX_A : BIT_US;
  localparam int unsigned CW     = $clog2(MAX_US + 1);

  tw_state_t        state;
  logic [POS_W-1:0] bit_idx;
  logic [63:0]      data_q;
  logic [15:0]      crc_q;
  logic [CW-1:0]    seg_len;
  logic             tick, seg_end, cur_bit, last_bit, accept;

  assign busy     = (state != TW_IDLE);
  assign accept   = !busy && start;
  assign last_bit = (bit_idx == POS_W'(FRAME_BITS - 1));

  tw_us_tick #(.CLKS_PER_US(CLKS_PER_US)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
  );

  tw_seg_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick),
    .seg_len(seg_len), .seg_end(seg_end)
  );

  tw_frame_source u_src (
    .pos(bit_idx), .data_q(data_q), .crc_q(crc_q), .bit_val(cur_bit)
  );

  always_comb begin
    case (state)
      TW_CHARGE:  seg_len = CW'(CHARGE_US);
      TW_GAP:     seg_len = cur_bit ? CW'(ONE_OFF_US) : CW'(ZERO_OFF_US);
      TW_CARRIER: seg_len = cur_bit ? CW'(BIT_US - ONE_OFF_US) : CW'(BIT_US - ZERO_OFF_US);
      TW_PROGRAM: seg_len = CW'(PROG_US);
      default:    seg_len = CW'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= TW_IDLE;
      bit_idx <= '0;
      data_q  <= '0;
      crc_q   <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        state   <= TW_CHARGE;
        bit_idx <= '0;
        data_q  <= tag_data;
        crc_q   <= tag_crc;
      end else if (seg_end) begin
        case (state)
          TW_CHARGE:  state <= TW_GAP;
          TW_GAP:     state <= TW_CARRIER;
          TW_CARRIER: begin
            if (last_bit) state <= TW_PROGRAM;
            else begin
              state   <= TW_GAP;
              bit_idx <= bit_idx + POS_W'(1);
            end
          end
          TW_PROGRAM: begin
            state <= TW_IDLE;
            done  <= 1'b1;
          end
          default:    state <= TW_IDLE;
        endcase
      end
    end
  end

  assign field_mod = (state == TW_GAP);

  // Field stays on while idle (R1)
  assert_idle_field_on_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !field_mod);

  // A gap only begins when the timer closes an interval (R3)
  assert_gap_on_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(field_mod) |-> $past(seg_end));

  // Completion is a single cycle and follows a busy cycle (R7)
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // A start seen while busy never rewinds the bit position (R8)
  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done) && (bit_idx >= $past(bit_idx)));

  // Captured payload is frozen while busy (R9)
  assert_payload_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(data_q) && $stable(crc_q)));

endmodule

// File: tb/tw_write_modulator_tb_top.sv
module tw_write_modulator_tb_top;
  localparam int CPU  = 2;
  localparam int CHG  = 20;
  localparam int BIT  = 10;
  localparam int ONE  = 5;
  localparam int ZERO = 2;
  localparam int PROG = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] tag_data = '0;
  logic [15:0] tag_crc = '0;
  logic        field_mod, busy, done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int inj_at = -1;

  always #5 clk = ~clk;

  tw_write_modulator #(
    .CLKS_PER_US(CPU), .CHARGE_US(CHG), .BIT_US(BIT),
    .ONE_OFF_US(ONE), .ZERO_OFF_US(ZERO), .PROG_US(PROG)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .tag_data(tag_data),
    .tag_crc(tag_crc), .field_mod(field_mod), .busy(busy), .done(done)
  );

  // Serial stream restated as one wide word, bit k sent k-th (R5, R6)
  function automatic logic [111:0] stream(input logic [63:0] d, input logic [15:0] c);
    return {8'h03, 8'h00, c[15:8], c[7:0], d, 8'hEB, 8'hBB};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Advance one cycle; may inject a mid-frame start and new inputs (R8, R9)
  task automatic step();
    if (cyc == inj_at) begin
      start    = 1'b1;
      tag_data = {$urandom, $urandom};
      tag_crc  = 16'($urandom);
    end else begin
      start = 1'b0;
    end
    @(negedge clk);
    cyc++;
  endtask

  task automatic run_frame(input logic [63:0] d, input logic [15:0] c, input bit inject);
    logic [111:0] s;
    int bad, run_bad, off;
    s = stream(d, c);
    run_bad = 0;
    tag_data = d;
    tag_crc  = c;
    cyc = 0;
    inj_at = inject ? (CHG*CPU + 10 + int'($urandom_range(0, 100*BIT*CPU))) : -1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2", "busy after start", busy, 1);
    bad = 0;
    for (int i = 0; i < CHG*CPU; i++) begin
      if (field_mod !== 1'b0) bad++;
      step();
    end
    chk(bad == 0, "R2", "charge interval cycles with field off", bad, 0);
    run_bad += bad;
    for (int k = 0; k < 112; k++) begin
      off = s[k] ? ONE : ZERO;
      bad = 0;
      for (int i = 0; i < off*CPU; i++) begin
        if (field_mod !== 1'b1) bad++;
        step();
      end
      for (int i = 0; i < (BIT-off)*CPU; i++) begin
        if (field_mod !== 1'b0) bad++;
        step();
      end
      run_bad += bad;
      if (s[k]) chk(bad == 0, "R3", $sformatf("one slot at bit %0d (R5 R6 order)", k), bad, 0);
      else      chk(bad == 0, "R4", $sformatf("zero slot at bit %0d (R5 R6 order)", k), bad, 0);
    end
    bad = 0;
    for (int i = 0; i < PROG*CPU; i++) begin
      if (field_mod !== 1'b0 || busy !== 1'b1 || done !== 1'b0) bad++;
      step();
    end
    chk(bad == 0, "R7", "programming interval", bad, 0);
    run_bad += bad;
    chk(done == 1'b1 && busy == 1'b0, "R7", "done pulse with busy low",
        {done, busy}, 2'b10);
    if (!(done == 1'b1 && busy == 1'b0)) run_bad++;
    step();
    chk(done == 1'b0 && field_mod == 1'b0, "R7", "done lasts one cycle", done, 0);
    if (inject)
      chk(run_bad == 0, "R8", "R9 frame intact after mid-frame start and input change",
          run_bad, 0);
    inj_at = -1;
    start = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk(field_mod == 1'b0 && busy == 1'b0 && done == 1'b0, "R1", "outputs in reset",
        {field_mod, busy, done}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(field_mod == 1'b0 && busy == 1'b0 && done == 1'b0, "R1", "idle outputs after reset",
        {field_mod, busy, done}, 0);
    run_frame(64'h0, 16'h0, 1'b0);
    run_frame({64{1'b1}}, 16'hFFFF, 1'b0);
    run_frame(64'h8000_0000_0000_0001, 16'h8001, 1'b1);
    for (int r = 0; r < 5; r++)
      run_frame({$urandom, $urandom}, 16'($urandom), r[0]);
    chk(field_mod == 1'b0 && busy == 1'b0, "R1", "idle after all runs",
        {field_mod, busy}, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule